// File: doc/BRIEF.md
# Top-Bit Precomputed Greater-Than Comparator

This block compares two unsigned operands and reports whether the first is strictly larger than the second. To limit switching it splits each operand in two. The most significant bit of each operand goes into a two-bit register that loads on every clock edge. All the remaining bits go into a much wider register that loads only when the top bits agree, because only then can the lower bits change the answer. When the top bits disagree, the wide register keeps its contents, so its bits and the lower-bit compare logic after it stay still.

The compare is evaluated from the registered state, so a result appears on the cycle after the operands are presented with `in_valid`. The load-disable decision is a combinational function of the incoming top bits and the valid flag. It is brought out on `load_dis_o` so that surrounding logic can watch it or count it.

Top module: `pcmp_gt_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `gt_o` is 0, and `load_dis_o` is 1 while `in_valid` is low.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: When `out_valid` is 1, `gt_o` is 1 exactly when the operands presented on the previous cycle satisfy `a_in > b_in` as unsigned numbers.
- R4: An operand pair presented with `in_valid` high, where bit WIDTH-1 of `a_in` is 1 and bit WIDTH-1 of `b_in` is 0, gives `gt_o` = 1 on the next cycle, whatever the lower bits are.
- R5: An operand pair presented with `in_valid` high, where bit WIDTH-1 of `a_in` is 0 and bit WIDTH-1 of `b_in` is 1, gives `gt_o` = 0 on the next cycle, whatever the lower bits are.
- R6: When the top bits are equal, the result follows the unsigned compare of bits WIDTH-2..0. Equal operands give 0.
- R7: `load_dis_o` is 1 in the same cycle whenever `in_valid` is 0 or the two incoming top bits differ, and 0 otherwise. The lower-bit register changes only after a cycle in which `load_dis_o` was 0.
- R8: While loading is disabled, the lower-bit register keeps its contents. `gt_o` is driven in every cycle from the most recently captured top bits and the retained lower bits, so retained bits show at the port when the next captured top bits are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | First operand, unsigned |
| b_in | input | WIDTH | Second operand, unsigned |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are valid this cycle |
| gt_o | output | 1 | 1 when the captured first operand exceeds the second |
| out_valid | output | 1 | `gt_o` belongs to a valid operand pair |
| load_dis_o | output | 1 | Lower-bit register is not loaded on the coming edge |

## Verification
A lower-bit register that loads when it should hold, or holds when it should load, shows up as a wrong `gt_o` at the first later cycle whose captured top bits are equal. A pair presented with `in_valid` low after a top-bit-decided pair exposes the retained bits one cycle later. A wrong top-bit decode shows on the very next cycle as a flipped result for operands whose top bits differ. An error in the disable logic shows in the same cycle on `load_dis_o`.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  typedef enum logic [1:0] {
    DEC_LOSE = 2'd0,
    DEC_WIN  = 2'd1,
    DEC_TIE  = 2'd2
  } msb_dec_e;

  // Outcome decided by the top bit pair alone.
  function automatic msb_dec_e msb_decide(input logic a_top, input logic b_top);
    if (a_top == b_top)     return DEC_TIE;
    else if (a_top)         return DEC_WIN;
    else                    return DEC_LOSE;
  endfunction

endpackage

// File: rtl/pcmp_msb_stage.sv
module pcmp_msb_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic a_top,
  input  logic b_top,
  input  logic in_valid,
  output logic a_top_q,
  output logic b_top_q,
  output logic vld_q,
  output logic load_en
);
  import pcmp_pkg::*;

  msb_dec_e dec_now;

  always_comb begin
    dec_now = msb_decide(a_top, b_top);
    load_en = in_valid && (dec_now == DEC_TIE);
  end

  // Precomputed-input register: captured on every edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_top_q <= 1'b0;
      b_top_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      a_top_q <= a_top;
      b_top_q <= b_top;
      vld_q   <= in_valid;
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vld_q == $past(in_valid))) else $error("valid delay"); // R2

endmodule

// File: rtl/pcmp_gated_reg.sv
module pcmp_gated_reg #(
  parameter int LOW_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [LOW_W-1:0] a_low,
  input  logic [LOW_W-1:0] b_low,
  output logic [LOW_W-1:0] a_low_q,
  output logic [LOW_W-1:0] b_low_q
);
  localparam int NOPS = 2;

  logic [LOW_W-1:0] d_arr [NOPS];
  logic [LOW_W-1:0] q_arr [NOPS];

  assign d_arr[0] = a_low;
  assign d_arr[1] = b_low;

  // One load-enabled lane per operand.
  for (genvar op = 0; op < NOPS; op++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_arr[op] <= '0;
      else if (load_en) q_arr[op] <= d_arr[op];
    end
  end

  assign a_low_q = q_arr[0];
  assign b_low_q = q_arr[1];

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(a_low_q) && $stable(b_low_q))) else $error("lower bits moved while held"); // R8
  AST_CHANGE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(a_low_q) || !$stable(b_low_q)) |-> $past(load_en)) else $error("lower bits changed without load"); // R7

endmodule

// File: rtl/pcmp_low_cmp.sv
module pcmp_low_cmp #(
  parameter int LOW_W     = 15,
  parameter int CMP_STYLE = 1   // 0: operator, 1: top-down bit scan
) (
  input  logic [LOW_W-1:0] a_low,
  input  logic [LOW_W-1:0] b_low,
  output logic             low_gt
);
  function automatic logic scan_gt(input logic [LOW_W-1:0] x, input logic [LOW_W-1:0] y);
    logic decided, res;
    decided = 1'b0;
    res     = 1'b0;
    for (int i = LOW_W - 1; i >= 0; i--) begin
      if (!decided && (x[i] != y[i])) begin
        decided = 1'b1;
        res     = x[i];
      end
    end
    return res;
  endfunction

  if (CMP_STYLE == 0) begin : g_op
    assign low_gt = (a_low > b_low);
  end else begin : g_scan
    assign low_gt = scan_gt(a_low, b_low);
  end

endmodule

// File: rtl/pcmp_gt_top.sv
module pcmp_gt_top #(
  parameter int WIDTH     = 16,
  parameter int CMP_STYLE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             in_valid,
  output logic             gt_o,
  output logic             out_valid,
  output logic             load_dis_o
);
  import pcmp_pkg::*;

  localparam int LOW_W = WIDTH - 1;

  logic             a_top_q, b_top_q, vld_q, load_en;
  logic [LOW_W-1:0] a_low_q, b_low_q;
  logic             low_gt;
  msb_dec_e         dec_q;

  pcmp_msb_stage u_msb (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_top    (a_in[WIDTH-1]),
    .b_top    (b_in[WIDTH-1]),
    .in_valid (in_valid),
    .a_top_q  (a_top_q),
    .b_top_q  (b_top_q),
    .vld_q    (vld_q),
    .load_en  (load_en)
  );

  pcmp_gated_reg #(.LOW_W(LOW_W)) u_low (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .a_low   (a_in[LOW_W-1:0]),
    .b_low   (b_in[LOW_W-1:0]),
    .a_low_q (a_low_q),
    .b_low_q (b_low_q)
  );

  pcmp_low_cmp #(.LOW_W(LOW_W), .CMP_STYLE(CMP_STYLE)) u_cmp (
    .a_low  (a_low_q),
    .b_low  (b_low_q),
    .low_gt (low_gt)
  );

  always_comb begin
    dec_q = msb_decide(a_top_q, b_top_q);
    unique case (dec_q)
      DEC_WIN:  gt_o = 1'b1;
      DEC_LOSE: gt_o = 1'b0;
      default:  gt_o = low_gt;
    endcase
  end

  assign out_valid  = vld_q;
  assign load_dis_o = !load_en;

  AST_TOP_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_in[WIDTH-1] && !b_in[WIDTH-1]) |=> gt_o) else $error("top win lost"); // R4
  AST_TOP_LOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_in[WIDTH-1] && b_in[WIDTH-1]) |=> !gt_o) else $error("top lose won"); // R5
  AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_in == b_in)) |=> !gt_o) else $error("equal gave 1"); // R6
  AST_DIFF_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in[WIDTH-1] != b_in[WIDTH-1]) |-> load_dis_o) else $error("load on differing tops"); // R7

endmodule

// File: tb/pcmp_gt_top_test.sv
module pcmp_gt_top_test;
  localparam int W     = 16;
  localparam int LW    = W - 1;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         in_valid = 1'b0;
  logic         gt_o, out_valid, load_dis_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  logic          m_ta = 0, m_tb = 0, m_vld = 0;
  logic [LW-1:0] m_la = '0, m_lb = '0;
  logic [W-1:0]  p_a = '0, p_b = '0;
  int            hold_seen = 0, hold_exp = 0;

  pcmp_gt_top #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .in_valid(in_valid),
    .gt_o(gt_o), .out_valid(out_valid), .load_dis_o(load_dis_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic ref_gt(input logic [W-1:0] x, input logic [W-1:0] y);
    return x > y;
  endfunction

  function automatic logic state_gt();
    if (m_ta != m_tb) return m_ta;
    return m_la > m_lb;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b a=%h b=%h", req, act, exp, p_a, p_b);
    end
  endtask

  // Called at a falling edge: checks last cycle, drives next.
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    logic exp_gt;
    chk(out_valid, m_vld, "R2");
    if (m_vld) begin
      exp_gt = ref_gt(p_a, p_b);
      if (p_a[W-1] & ~p_b[W-1])      chk(gt_o, exp_gt, "R4");
      else if (~p_a[W-1] & p_b[W-1]) chk(gt_o, exp_gt, "R5");
      else                           chk(gt_o, exp_gt, "R6");
      chk(gt_o, state_gt(), "R3");
    end else begin
      chk(gt_o, state_gt(), "R8");
    end
    a_in = a; b_in = b; in_valid = v;
    #1;
    chk(load_dis_o, !(v && (a[W-1] == b[W-1])), "R7");
    if (v && load_dis_o) hold_seen++;
    if (v && (a[W-1] != b[W-1])) hold_exp++;
    m_ta = a[W-1]; m_tb = b[W-1]; m_vld = v;
    if (v && (a[W-1] == b[W-1])) begin
      m_la = a[LW-1:0]; m_lb = b[LW-1:0];
    end
    p_a = a; p_b = b;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid, 1'b0, "R1");
    chk(gt_o, 1'b0, "R1");
    chk(load_dis_o, 1'b1, "R1");

    // directed corners
    step(1, 16'h8000, 16'h7FFF);   // R4 tops decide
    step(1, 16'h7FFF, 16'h8000);   // R5
    step(1, 16'h1234, 16'h1234);   // R6 equal
    step(1, 16'h0001, 16'h0000);   // R6 low decides
    step(1, 16'hFFFF, 16'hFFFE);
    step(1, 16'h0000, 16'hFFFF);
    // R8: load low 5>3, hold on differing tops, then expose retained bits
    step(1, 16'h0005, 16'h0003);
    step(1, 16'h8000, 16'h0007);
    step(0, 16'h0001, 16'h0009);
    step(0, 16'h0000, 16'h0000);
    step(1, 16'h0002, 16'h0004);
    step(0, 16'h8001, 16'h0000);
    step(0, 16'h0000, 16'h0000);

    for (int i = 0; i < 3000; i++) begin
      int mode;
      ra   = W'($urandom);
      mode = int'($urandom % 4);
      case (mode)
        0: rb = ra;
        1: rb = ra ^ (W'(1) << ($urandom % LW));
        default: rb = W'($urandom);
      endcase
      step(($urandom % 4) != 0, ra, rb);
    end
    step(0, '0, '0);

    chk(1'(hold_seen == hold_exp), 1'b1, "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule